// File: doc/BRIEF.md
# Set-Associative Data Cache with Per-Read Volatile Policy

This block is a small write-back data cache between one load/store client and two memory back-ends. Address bit 31 picks the back-end. When the bit is 0, the access goes to device memory, which is reachable only through this cache. When the bit is 1, the access goes to host memory, which another agent may change at any time. The cache has four sets and two ways, with 16-byte lines. Write-back and write-allocate apply to both regions.

Every read carries a 2-bit operator tag that sets the policy for that one access. There is no global switch that turns caching on or off. Encodings: 00 normal, 01 streaming, 10 volatile, 11 reserved (handled as normal). A volatile read to host memory is never answered from a resident line. If the line is dirty it is first written back to host memory, then invalidated, and then the data is fetched again. A volatile read to device memory is handled as a streaming read: it may hit, and its line becomes the first candidate for eviction.

The client uses a valid/ready handshake and gets a one-cycle read response pulse. Each back-end uses a valid/ready request and a one-cycle response pulse that carries a whole line. Only one miss is in flight at a time. Four counters (hits, misses, volatile refetches, write-backs) are visible at the ports.

Top module: `cvc_top`

## Requirements
- R1: A read whose line is not resident is sent as one line-aligned read to the back-end chosen by address bit 31 (1 = host, 0 = device). The read then returns the 32-bit word selected by address bits 3:2 and increments the miss counter.
- R2: A normal read of a resident line returns the cached word and increments the hit counter. It sends no back-end request, even when the back-end copy has changed since the fill.
- R3: A volatile read (operator 10) to a host address whose line is resident is never served as a hit. It increments the miss and volatile-refetch counters and leaves the hit counter unchanged. It returns the current host-memory word on every such read.
- R4: When the resident line is dirty at a volatile host read, the line is written to host memory first and the write-back counter increments. The line is then refetched, and the read returns the written-back data.
- R5: A volatile read to a device address behaves as a streaming read. It hits when the line is resident, and its line becomes the first victim of the next miss in its set.
- R6: A line filled or touched by a streaming read (operator 01) is ranked least recently used. The next miss in its set evicts that line rather than the other way.
- R7: Operator 11 behaves exactly like operator 00 for hits and for replacement ranking.
- R8: Writes are write-back and write-allocate. A write hit marks the line dirty and does not update the back-end. Evicting a dirty line writes the whole line to the back-end of its own region and increments the write-back counter.
- R9: While a write-back or refill is in progress, req_ready stays low. At most one back-end request is valid in any cycle, and each back-end only receives addresses of its own region.
- R10: After reset, all counters are zero, req_ready is high, resp_valid is low, and no line is resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op | input | 2 | Read operator tag: 00 normal, 01 streaming, 10 volatile, 11 as normal |
| req_addr | input | 32 | Byte address; bit 31 selects host region |
| req_wdata | input | 32 | Write word |
| resp_valid | output | 1 | One-cycle read data pulse |
| resp_rdata | output | 32 | Read word |
| dev_req_valid | output | 1 | Device back-end request valid |
| dev_req_ready | input | 1 | Device back-end accepts request |
| dev_req_write | output | 1 | Device request is a line write |
| dev_req_addr | output | 32 | Line-aligned device address |
| dev_req_wdata | output | 128 | Line written to device |
| dev_resp_valid | input | 1 | Device read line valid |
| dev_resp_data | input | 128 | Device read line |
| host_req_valid | output | 1 | Host back-end request valid |
| host_req_ready | input | 1 | Host back-end accepts request |
| host_req_write | output | 1 | Host request is a line write |
| host_req_addr | output | 32 | Line-aligned host address |
| host_req_wdata | output | 128 | Line written to host |
| host_resp_valid | input | 1 | Host read line valid |
| host_resp_data | input | 128 | Host read line |
| cnt_hit | output | 16 | Accesses served from a resident line |
| cnt_miss | output | 16 | Accesses that needed a refill |
| cnt_vrefetch | output | 16 | Volatile host reads that found the line resident |
| cnt_wb | output | 16 | Lines written back |

## Verification
The response for a hit leaves the cache in the same cycle that the next client request can be accepted. The return of one read and the acceptance of the next can therefore fall in the same cycle. The bench provokes this by issuing two device-region hits back to back without waiting for the first response. It judges the result in two ways: the scoreboard must pop both words in order with their own values, and the hit counter must rise by exactly two. Volatile host refetches are judged by changing host memory behind the cache between reads, and by expecting each new value while the hit counter stays unchanged.

// File: rtl/cvc_pkg.sv
// Shared types for the volatile-policy cache.
// Assumes: operator encoding is fixed by the client interface.
package cvc_pkg;
    typedef enum logic [1:0] {
        OP_NORMAL   = 2'b00,
        OP_STREAM   = 2'b01,
        OP_VOLATILE = 2'b10,
        OP_RSVD     = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WB,
        ST_FILL_REQ,
        ST_FILL_WAIT
    } state_e;
endpackage

// File: rtl/cvc_store.sv
// Tag, data, state and replacement storage for a 2-way cache.
// One combinational read port (by set index) and one write port per way.
// Assumes: valid, dirty and replacement bits are reset; tags and data are not.
module cvc_store #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 26,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [1:0]                 rd_valid,
    output logic [1:0]                 rd_dirty,
    output logic [1:0][TAG_W-1:0]      rd_tag,
    output logic [1:0][LINE_W-1:0]     rd_data,
    output logic                       rd_lru,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic                       wr_way,
    input  logic                       wr_valid,
    input  logic                       wr_dirty,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [LINE_W-1:0]          wr_data,
    input  logic                       lru_we,
    input  logic [IDX_W-1:0]           lru_idx,
    input  logic                       lru_val
);
    logic [SETS-1:0] lru_q;

    // Replacement bit per set: the way to evict next.
    always_ff @(posedge clk) begin
        if (!rst_n)      lru_q <= '0;
        else if (lru_we) lru_q[lru_idx] <= lru_val;
    end
    assign rd_lru = lru_q[rd_idx];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]   v_q;
        logic [SETS-1:0]   d_q;
        logic [TAG_W-1:0]  t_q [SETS];
        logic [LINE_W-1:0] l_q [SETS];

        // Valid and dirty bits for this way.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= '0;
                d_q <= '0;
            end else if (wr_en && (wr_way == 1'(w))) begin
                v_q[wr_idx] <= wr_valid;
                d_q[wr_idx] <= wr_dirty;
            end
        end

        // Tag and line payload for this way.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) begin
                t_q[wr_idx] <= wr_tag;
                l_q[wr_idx] <= wr_data;
            end
        end

        assign rd_valid[w] = v_q[rd_idx];
        assign rd_dirty[w] = d_q[rd_idx];
        assign rd_tag[w]   = t_q[rd_idx];
        assign rd_data[w]  = l_q[rd_idx];

        // A dirty line is always a resident line.
        assert_dirty_resident_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (d_q & ~v_q) == '0);
    end
endmodule

// File: rtl/cvc_policy.sv
// Lookup and per-request policy: tag match, victim choice, and the
// effect of the operator tag combined with the address region.
// Assumes: exactly two ways; operator applies to reads only.
module cvc_policy
    import cvc_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  op_e                    op,
    input  logic                   is_write,
    input  logic                   host,
    input  logic [1:0]             valid,
    input  logic [1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]       req_tag,
    input  logic                   lru,
    output logic                   hit,
    output logic                   hit_way,
    output logic                   victim,
    output logic                   evict_first,
    output logic                   force_refetch
);
    logic [1:0] match;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == req_tag);
    end

    // Hit detection and replacement victim.
    always_comb begin
        hit     = |match;
        hit_way = match[1];
        if (!valid[0])      victim = 1'b0;
        else if (!valid[1]) victim = 1'b1;
        else                victim = lru;
    end

    // Operator decode: reserved code falls through to normal.
    always_comb begin
        force_refetch = !is_write && (op == OP_VOLATILE) && host;
        evict_first   = !is_write && ((op == OP_STREAM) || (op == OP_VOLATILE));
    end
endmodule

// File: rtl/cvc_top.sv
// Two-way write-back data cache with a per-read operator tag.
// Top address bit selects host (1) or device (0) back-end. Volatile host
// reads always refetch (after writing back a dirty copy); streaming and
// volatile device reads rank their line for early eviction.
// Assumes: one miss in flight; back-ends answer reads with one line pulse.
module cvc_top
    import cvc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int CNT_W      = 16,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              dev_req_valid,
    input  logic              dev_req_ready,
    output logic              dev_req_write,
    output logic [ADDR_W-1:0] dev_req_addr,
    output logic [LINE_W-1:0] dev_req_wdata,
    input  logic              dev_resp_valid,
    input  logic [LINE_W-1:0] dev_resp_data,
    output logic              host_req_valid,
    input  logic              host_req_ready,
    output logic              host_req_write,
    output logic [ADDR_W-1:0] host_req_addr,
    output logic [LINE_W-1:0] host_req_wdata,
    input  logic              host_resp_valid,
    input  logic [LINE_W-1:0] host_resp_data,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_vrefetch,
    output logic [CNT_W-1:0]  cnt_wb
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WSEL_W = $clog2(LINE_BYTES / 4);

    state_e            state;
    logic              r_write;
    op_e               r_op;
    logic [ADDR_W-1:0] r_addr;
    logic [31:0]       r_wdata;
    logic              way_q;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  rtag;
    logic [WSEL_W-1:0] wsel;
    logic              host;
    logic              unused_lowbits;

    assign idx  = r_addr[OFF_W +: IDX_W];
    assign rtag = r_addr[ADDR_W-1 -: TAG_W];
    assign wsel = r_addr[2 +: WSEL_W];
    assign host = r_addr[ADDR_W-1];
    assign unused_lowbits = ^r_addr[1:0];

    logic [1:0]              st_valid, st_dirty;
    logic [1:0][TAG_W-1:0]   st_tag;
    logic [1:0][LINE_W-1:0]  st_data;
    logic                    st_lru;
    logic                    wr_en, wr_way, wr_valid, wr_dirty;
    logic [TAG_W-1:0]        wr_tag;
    logic [LINE_W-1:0]       wr_data;
    logic                    lru_we, lru_val;

    logic hit, hit_way, victim, evict_first, force_refetch, tgt;

    cvc_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(idx),
        .rd_valid(st_valid), .rd_dirty(st_dirty), .rd_tag(st_tag),
        .rd_data(st_data), .rd_lru(st_lru),
        .wr_en(wr_en), .wr_idx(idx), .wr_way(wr_way), .wr_valid(wr_valid),
        .wr_dirty(wr_dirty), .wr_tag(wr_tag), .wr_data(wr_data),
        .lru_we(lru_we), .lru_idx(idx), .lru_val(lru_val)
    );

    cvc_policy #(.TAG_W(TAG_W)) u_policy (
        .op(r_op), .is_write(r_write), .host(host),
        .valid(st_valid), .tags(st_tag), .req_tag(rtag), .lru(st_lru),
        .hit(hit), .hit_way(hit_way), .victim(victim),
        .evict_first(evict_first), .force_refetch(force_refetch)
    );

    assign tgt = hit ? hit_way : victim;

    // Back-end routing: write-back follows the victim's region, fill the request's.
    logic              bk_host, bk_valid, bk_ready, fill_valid;
    logic [ADDR_W-1:0] bk_addr;
    logic [LINE_W-1:0] fill_line;
    always_comb begin
        bk_host    = (state == ST_WB) ? st_tag[way_q][TAG_W-1] : host;
        bk_valid   = (state == ST_WB) || (state == ST_FILL_REQ);
        bk_ready   = bk_host ? host_req_ready : dev_req_ready;
        fill_valid = host ? host_resp_valid : dev_resp_valid;
        fill_line  = host ? host_resp_data : dev_resp_data;
        bk_addr    = (state == ST_WB) ? {st_tag[way_q], idx, {OFF_W{1'b0}}}
                                      : {r_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    assign dev_req_valid  = bk_valid && !bk_host;
    assign host_req_valid = bk_valid && bk_host;
    assign dev_req_write  = (state == ST_WB);
    assign host_req_write = (state == ST_WB);
    assign dev_req_addr   = bk_addr;
    assign host_req_addr  = bk_addr;
    assign dev_req_wdata  = st_data[way_q];
    assign host_req_wdata = st_data[way_q];
    assign req_ready      = (state == ST_IDLE);

    // Store update: write hits, volatile invalidation, write-back drop, refill.
    logic [LINE_W-1:0] merged;
    always_comb begin
        merged = (state == ST_CHECK) ? st_data[hit_way] : fill_line;
        merged[wsel*32 +: 32] = r_wdata;
        wr_en = 1'b0; wr_way = way_q; wr_valid = 1'b0; wr_dirty = 1'b0;
        wr_tag = rtag; wr_data = st_data[way_q];
        lru_we = 1'b0; lru_val = 1'b0;
        case (state)
            ST_CHECK: begin
                if (hit && !force_refetch) begin
                    lru_we  = 1'b1;
                    lru_val = evict_first ? hit_way : ~hit_way;
                    if (r_write) begin
                        wr_en = 1'b1; wr_way = hit_way; wr_valid = 1'b1;
                        wr_dirty = 1'b1; wr_data = merged;
                    end
                end else if (hit && !st_dirty[hit_way]) begin
                    wr_en = 1'b1; wr_way = hit_way;
                end
            end
            ST_WB: wr_en = bk_ready;
            ST_FILL_WAIT: begin
                if (fill_valid) begin
                    wr_en = 1'b1; wr_valid = 1'b1; wr_dirty = r_write;
                    wr_data = r_write ? merged : fill_line;
                    lru_we  = 1'b1;
                    lru_val = evict_first ? way_q : ~way_q;
                end
            end
            default: ;
        endcase
    end

    // Control sequence, response register and event counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; r_write <= 1'b0; r_op <= OP_NORMAL;
            r_addr <= '0; r_wdata <= '0; way_q <= 1'b0;
            resp_valid <= 1'b0; resp_rdata <= '0;
            cnt_hit <= '0; cnt_miss <= '0; cnt_vrefetch <= '0; cnt_wb <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    r_write <= req_write; r_op <= op_e'(req_op);
                    r_addr <= req_addr; r_wdata <= req_wdata;
                    state <= ST_CHECK;
                end
                ST_CHECK: if (hit && !force_refetch) begin
                    cnt_hit <= cnt_hit + 1'b1;
                    if (!r_write) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= st_data[hit_way][wsel*32 +: 32];
                    end
                    state <= ST_IDLE;
                end else begin
                    cnt_miss <= cnt_miss + 1'b1;
                    if (hit) cnt_vrefetch <= cnt_vrefetch + 1'b1;
                    way_q <= tgt;
                    state <= (st_valid[tgt] && st_dirty[tgt]) ? ST_WB : ST_FILL_REQ;
                end
                ST_WB: if (bk_ready) begin
                    cnt_wb <= cnt_wb + 1'b1;
                    state  <= ST_FILL_REQ;
                end
                ST_FILL_REQ: if (bk_ready) state <= ST_FILL_WAIT;
                ST_FILL_WAIT: if (fill_valid) begin
                    if (!r_write) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= fill_line[wsel*32 +: 32];
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_stall_on_backend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req_valid || host_req_valid) |-> !req_ready);
    assert_one_backend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_req_valid && host_req_valid));
    assert_device_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req_valid |-> !dev_req_addr[ADDR_W-1]);
    assert_host_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_valid |-> host_req_addr[ADDR_W-1]);
    assert_volatile_host_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && !r_write && r_op == OP_VOLATILE && host)
        |=> ($stable(cnt_hit) && !req_ready));
endmodule

// File: tb/cvc_top_test.sv
`timescale 1ns/1ps
module cvc_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, resp_valid;
    logic [31:0] resp_rdata;
    logic        dev_req_valid, dev_req_write, host_req_valid, host_req_write;
    logic [31:0] dev_req_addr, host_req_addr;
    logic [127:0] dev_req_wdata, host_req_wdata;
    logic        dev_resp_valid = 1'b0, host_resp_valid = 1'b0;
    logic [127:0] dev_resp_data = '0, host_resp_data = '0;
    logic [15:0] cnt_hit, cnt_miss, cnt_vrefetch, cnt_wb;

    cvc_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .dev_req_valid(dev_req_valid), .dev_req_ready(1'b1),
        .dev_req_write(dev_req_write), .dev_req_addr(dev_req_addr),
        .dev_req_wdata(dev_req_wdata), .dev_resp_valid(dev_resp_valid),
        .dev_resp_data(dev_resp_data),
        .host_req_valid(host_req_valid), .host_req_ready(1'b1),
        .host_req_write(host_req_write), .host_req_addr(host_req_addr),
        .host_req_wdata(host_req_wdata), .host_resp_valid(host_resp_valid),
        .host_resp_data(host_resp_data),
        .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_vrefetch(cnt_vrefetch),
        .cnt_wb(cnt_wb)
    );

    int n_tests = 0, n_fail = 0;
    int dev_rd_n = 0, dev_wr_n = 0, host_rd_n = 0, host_wr_n = 0;
    int dev_wait = 0, host_wait = 0, r9_viol = 0;
    int exp_h = 0, exp_m = 0, exp_v = 0, exp_w = 0;
    logic [31:0] dev_pend, host_pend;
    logic [127:0] dev_mem [logic [31:0]];
    logic [127:0] host_mem [logic [31:0]];
    logic [31:0] exp_d [$];
    string       exp_tag [$];

    function automatic logic [31:0] init_word(logic [31:0] a);
        return {a[31:16] ^ 16'h5A5A, a[15:2], 2'b01};
    endfunction

    function automatic logic [127:0] get_line(bit h, logic [31:0] la);
        logic [127:0] l;
        if (h && host_mem.exists(la)) return host_mem[la];
        if (!h && dev_mem.exists(la)) return dev_mem[la];
        for (int i = 0; i < 4; i++) l[i*32 +: 32] = init_word(la + 32'(i * 4));
        return l;
    endfunction

    function automatic logic [31:0] mem_word(bit h, logic [31:0] a);
        logic [127:0] l = get_line(h, {a[31:4], 4'h0});
        return l[a[3:2]*32 +: 32];
    endfunction

    task automatic agent_write(logic [31:0] a, logic [31:0] v);
        logic [127:0] l = get_line(1'b1, {a[31:4], 4'h0});
        l[a[3:2]*32 +: 32] = v;
        host_mem[{a[31:4], 4'h0}] = l;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Device back-end model: fixed ready, read data two cycles later.
    always @(negedge clk) begin
        dev_resp_valid = 1'b0;
        if (dev_wait > 0) begin
            dev_wait--;
            if (dev_wait == 0) begin
                dev_resp_valid = 1'b1;
                dev_resp_data  = get_line(1'b0, dev_pend);
            end
        end
        if (rst_n && dev_req_valid) begin
            if (dev_req_write) begin dev_mem[dev_req_addr] = dev_req_wdata; dev_wr_n++; end
            else begin dev_rd_n++; dev_pend = dev_req_addr; dev_wait = 2; end
        end
    end

    // Host back-end model: same timing, contents changeable by the agent.
    always @(negedge clk) begin
        host_resp_valid = 1'b0;
        if (host_wait > 0) begin
            host_wait--;
            if (host_wait == 0) begin
                host_resp_valid = 1'b1;
                host_resp_data  = get_line(1'b1, host_pend);
            end
        end
        if (rst_n && host_req_valid) begin
            if (host_req_write) begin host_mem[host_req_addr] = host_req_wdata; host_wr_n++; end
            else begin host_rd_n++; host_pend = host_req_addr; host_wait = 2; end
        end
    end

    // Scoreboard monitor: pops one expected word per response.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((dev_req_valid || host_req_valid) && req_ready) r9_viol++;
            if (dev_req_valid && host_req_valid) r9_viol++;
            if (resp_valid) begin
                if (exp_d.size() == 0) check("R1 unexpected response", resp_rdata, 32'hx);
                else check(exp_tag.pop_front(), resp_rdata, exp_d.pop_front());
            end
        end
    end

    task automatic drive(bit wr, logic [31:0] a, logic [1:0] op, logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_op = op; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic rd(logic [31:0] a, logic [1:0] op, logic [31:0] e, string tag);
        exp_d.push_back(e); exp_tag.push_back(tag);
        drive(1'b0, a, op, 32'h0);
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] v);
        drive(1'b1, a, 2'b00, v);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(req_ready && !resp_valid && exp_d.size() == 0));
    endtask

    task automatic check_counts(string tag);
        check({tag, " hits"}, 32'(cnt_hit), exp_h);
        check({tag, " misses"}, 32'(cnt_miss), exp_m);
        check({tag, " refetches"}, 32'(cnt_vrefetch), exp_v);
        check({tag, " write-backs"}, 32'(cnt_wb), exp_w);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 req_ready", 32'(req_ready), 1);
        check("R10 resp_valid", 32'(resp_valid), 0);
        check_counts("R10");

        // R1: device miss fills from device back-end
        rd(32'h0000_0004, 2'b00, init_word(32'h4), "R1 device miss data"); wait_idle();
        exp_m++; check_counts("R1");
        // R2: normal hit, no back-end traffic
        rd(32'h0000_0008, 2'b00, init_word(32'h8), "R2 device hit data"); wait_idle();
        exp_h++; check("R2 no refill", dev_rd_n, 1);
        // R8: write hit stays in cache
        wr(32'h0000_000C, 32'h1111_2222); wait_idle(); exp_h++;
        rd(32'h0000_000C, 2'b00, 32'h1111_2222, "R8 write hit readback"); wait_idle(); exp_h++;
        check("R8 device not updated", mem_word(1'b0, 32'hC), init_word(32'hC));

        // R1/R2/R3: host region, stale hit vs volatile refetch
        rd(32'h8000_0000, 2'b00, init_word(32'h8000_0000), "R1 host miss data"); wait_idle(); exp_m++;
        agent_write(32'h8000_0000, 32'hAAAA_0001);
        rd(32'h8000_0000, 2'b00, init_word(32'h8000_0000), "R2 host stale hit"); wait_idle(); exp_h++;
        rd(32'h8000_0000, 2'b10, 32'hAAAA_0001, "R3 volatile refetch 1"); wait_idle(); exp_m++; exp_v++;
        agent_write(32'h8000_0000, 32'hAAAA_0002);
        rd(32'h8000_0000, 2'b10, 32'hAAAA_0002, "R3 volatile refetch 2"); wait_idle(); exp_m++; exp_v++;
        check("R3 host reads", host_rd_n, 3);
        check_counts("R3");

        // R4: dirty line written back before volatile refetch
        wr(32'h8000_0004, 32'hBEEF_0004); wait_idle(); exp_h++;
        rd(32'h8000_0004, 2'b10, 32'hBEEF_0004, "R4 refetch after write-back"); wait_idle();
        exp_m++; exp_v++; exp_w++;
        check("R4 host write count", host_wr_n, 1);
        check("R4 host memory word", mem_word(1'b1, 32'h8000_0004), 32'hBEEF_0004);
        check_counts("R4");

        // R2: back-to-back hits, response and next accept in one cycle
        rd(32'h0000_0000, 2'b00, init_word(32'h0), "R2 back-to-back first");
        rd(32'h0000_0008, 2'b00, init_word(32'h8), "R2 back-to-back second");
        wait_idle(); exp_h += 2; check_counts("R2");

        // R5/R8: set 3, volatile device line is evicted first, dirty eviction
        wr(32'h0000_0070, 32'h7777_0070); wait_idle(); exp_m++;
        rd(32'h0000_0030, 2'b10, init_word(32'h30), "R5 volatile device miss"); wait_idle(); exp_m++;
        rd(32'h0000_0034, 2'b10, init_word(32'h34), "R5 volatile device hit"); wait_idle(); exp_h++;
        rd(32'h0000_00B0, 2'b00, init_word(32'hB0), "R5 conflict miss"); wait_idle(); exp_m++;
        rd(32'h0000_0070, 2'b00, 32'h7777_0070, "R5 normal line kept"); wait_idle(); exp_h++;
        check_counts("R5");
        rd(32'h0000_00F0, 2'b00, init_word(32'hF0), "R8 fill"); wait_idle(); exp_m++;
        rd(32'h0000_0130, 2'b00, init_word(32'h130), "R8 dirty victim fill"); wait_idle(); exp_m++; exp_w++;
        check("R8 device write count", dev_wr_n, 1);
        check("R8 device memory word", mem_word(1'b0, 32'h70), 32'h7777_0070);
        check_counts("R8");

        // R6: set 2, streaming line evicted first
        rd(32'h0000_0020, 2'b00, init_word(32'h20), "R6 normal fill"); wait_idle(); exp_m++;
        rd(32'h0000_0060, 2'b01, init_word(32'h60), "R6 streaming fill"); wait_idle(); exp_m++;
        rd(32'h0000_00A0, 2'b00, init_word(32'hA0), "R6 conflict"); wait_idle(); exp_m++;
        rd(32'h0000_0024, 2'b00, init_word(32'h24), "R6 normal kept"); wait_idle(); exp_h++;
        rd(32'h0000_0064, 2'b01, init_word(32'h64), "R6 streaming evicted"); wait_idle(); exp_m++;
        check_counts("R6");

        // R7: set 1, reserved operator ranks like normal
        rd(32'h0000_0010, 2'b11, init_word(32'h10), "R7 reserved fill"); wait_idle(); exp_m++;
        rd(32'h0000_0050, 2'b00, init_word(32'h50), "R7 normal fill"); wait_idle(); exp_m++;
        rd(32'h0000_0014, 2'b11, init_word(32'h14), "R7 reserved hit"); wait_idle(); exp_h++;
        rd(32'h0000_0090, 2'b00, init_word(32'h90), "R7 conflict"); wait_idle(); exp_m++;
        rd(32'h0000_0018, 2'b11, init_word(32'h18), "R7 reserved kept"); wait_idle(); exp_h++;
        check_counts("R7");

        check("R9 stall and single back-end", r9_viol, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule